// File: doc/BRIEF.md
# Posted Store Buffer with Conflict Drain

This block sits between a write-through data cache and the external memory port. Stores that have been written into the cache are also placed, one cache block at a time, into a small queue. The queue sends them off-chip one at a time, oldest first. A store can therefore finish without waiting for external memory.

A load that misses the cache first checks its block address against every occupied slot of the queue. When no slot matches, the read goes out to memory ahead of the older writes that are still waiting. When any slot matches, the block enters a drain mode. It refuses new stores and writes out every queued block, matching or not. Only then does it issue the read. The load data always comes from external memory, because the block never hands queued store data to a load.

Top module: `store_drain_buffer`

## Requirements
- R1: After reset, `fill_level` is 0, `drain_active` is 0, `mem_req_valid` is 0, `st_ready` is 1 and `ld_rsp_valid` is 0.
- R2: A store is accepted (`st_valid` and `st_ready`) only while fewer than DEPTH blocks are queued, and each accepted store raises `fill_level` by one. When `fill_level` equals DEPTH, `st_ready` is 0, and a store offered then leaves `fill_level` unchanged.
- R3: Queued blocks go to memory oldest first, as write requests (`mem_req_write` = 1). A write request carries address {block, OFFS_W zero bits} and the stored data. A block is released when `mem_ack` is sampled high, and `fill_level` is one lower on the following cycle.
- R4: Only one memory request is outstanding at a time. While `mem_req_valid` is high and `mem_ack` is low, the request's valid, write flag, address and data stay unchanged on the next cycle.
- R5: A pending load miss whose block matches no queued slot is issued as a read (`mem_req_write` = 0, address = `ld_addr`). The read follows any write already on the memory port and comes before the remaining queued writes.
- R6: A load matches a slot when `ld_addr` bits [ADDR_W-1:OFFS_W] equal that slot's block number. The low OFFS_W bits take no part in the comparison.
- R7: A load that matches any slot raises `drain_active`. Every queued block, including those that do not match, is written to memory before the read is requested. `fill_level` is 0 when `drain_active` falls.
- R8: While `drain_active` is high, `st_ready` is 0 and an offered store is not queued.
- R9: `ld_rsp_valid` pulses only in the cycle the read request is acknowledged, and `ld_rsp_data` is then `mem_rdata`. A write acknowledge never produces a load response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| st_valid | input | 1 | Store block offered |
| st_ready | output | 1 | Store block accepted this cycle |
| st_blk | input | ADDR_W-OFFS_W | Block number of the store |
| st_data | input | DATA_W | Block data of the store |
| ld_valid | input | 1 | Load miss pending; held until the response |
| ld_addr | input | ADDR_W | Byte address of the load miss |
| ld_rsp_valid | output | 1 | Load data returned |
| ld_rsp_data | output | DATA_W | Load data, taken from memory |
| mem_req_valid | output | 1 | Memory request active |
| mem_req_write | output | 1 | 1 = write of a queued block, 0 = load read |
| mem_req_addr | output | ADDR_W | Memory request address |
| mem_req_data | output | DATA_W | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| fill_level | output | $clog2(DEPTH+1) | Number of queued blocks |
| drain_active | output | 1 | Conflict drain in progress |

## Verification
The bench builds the block with its defaults: DEPTH 4, ADDR_W 16, OFFS_W 3, DATA_W 64. This small queue lets the sweep cover every fill level from empty to full. For each fill level it tries a load that matches each occupied slot in turn, plus a load that matches none. Each of these cases runs with a memory acknowledge latency of 0, 1 and 2 cycles. The sweep therefore reaches the following cases:
- a conflict on the slot already being written;
- a conflict on the newest slot;
- a drain where acknowledges arrive back to back;
- a full queue refusing a store.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  typedef enum logic [1:0] {
    SDB_IDLE  = 2'd0,
    SDB_WRITE = 2'd1,
    SDB_DRAIN = 2'd2,
    SDB_READ  = 2'd3
  } sdb_state_e;
endpackage

// File: rtl/sdb_store_queue.sv
module sdb_store_queue #(
  parameter  int DEPTH  = 4,
  parameter  int BLK_AW = 13,
  parameter  int DATA_W = 64,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [BLK_AW-1:0] push_blk,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic [BLK_AW-1:0] probe_blk,
  output logic              probe_hit,
  output logic [BLK_AW-1:0] head_blk,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count,
  output logic              full
);

  logic [BLK_AW-1:0] blk_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  vld_q, vld_d, hit_vec;
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = push ? bump(wr_q) : wr_q;
    rd_d  = pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign vld_d[i]   = (vld_q[i] & ~(pop && rd_q == PTR_W'(i)))
                      | (push && wr_q == PTR_W'(i));
    assign hit_vec[i] = vld_q[i] && (blk_q[i] == probe_blk);

    always_ff @(posedge clk) begin
      if (push && wr_q == PTR_W'(i)) begin
        blk_q[i]  <= push_blk;
        data_q[i] <= push_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      vld_q <= vld_d;
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  assign probe_hit = |hit_vec;
  assign head_blk  = blk_q[rd_q];
  assign head_data = data_q[rd_q];
  assign count     = cnt_q;
  assign full      = (cnt_q == CNT_W'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0)); // R3
  AST_COUNT_TRACKS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(cnt_q)); // R3

endmodule

// File: rtl/sdb_drain_ctrl.sv
module sdb_drain_ctrl
  import sdb_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic             ld_hit,
  input  logic [CNT_W-1:0] q_count,
  input  logic             mem_ack,
  output logic             req_valid,
  output logic             req_write,
  output logic             pop,
  output logic             rsp_fire,
  output logic             draining
);

  sdb_state_e state_q, state_d;
  logic       last_one;
  logic       conflict;

  assign last_one = (q_count == CNT_W'(1));
  assign conflict = ld_valid && ld_hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SDB_IDLE: begin
        if (ld_valid)             state_d = ld_hit ? SDB_DRAIN : SDB_READ;
        else if (q_count != '0)   state_d = SDB_WRITE;
      end
      SDB_WRITE: begin
        if (mem_ack) begin
          if (conflict)           state_d = last_one ? SDB_READ : SDB_DRAIN;
          else                    state_d = SDB_IDLE;
        end else if (conflict)    state_d = SDB_DRAIN;
      end
      SDB_DRAIN: begin
        if (mem_ack && last_one)  state_d = SDB_READ;
      end
      SDB_READ: begin
        if (mem_ack)              state_d = SDB_IDLE;
      end
      default:                    state_d = SDB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SDB_IDLE;
    else        state_q <= state_d;
  end

  assign req_valid = (state_q != SDB_IDLE);
  assign req_write = (state_q == SDB_WRITE) || (state_q == SDB_DRAIN);
  assign pop       = mem_ack && req_write;
  assign rsp_fire  = mem_ack && (state_q == SDB_READ);
  assign draining  = (state_q == SDB_DRAIN);

  AST_DRAIN_ENDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(draining) |-> (q_count == '0)); // R7
  AST_DRAIN_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    draining |-> (q_count != '0)); // R7

endmodule

// File: rtl/store_drain_buffer.sv
module store_drain_buffer #(
  parameter  int ADDR_W = 16,
  parameter  int OFFS_W = 3,
  parameter  int DATA_W = 64,
  parameter  int DEPTH  = 4,
  localparam int BLK_AW = ADDR_W - OFFS_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [BLK_AW-1:0] st_blk,
  input  logic [DATA_W-1:0] st_data,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_rsp_valid,
  output logic [DATA_W-1:0] ld_rsp_data,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_data,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  fill_level,
  output logic              drain_active
);

  logic              push, pop, full, hit, draining;
  logic [BLK_AW-1:0] head_blk;
  logic [DATA_W-1:0] head_data;
  logic [CNT_W-1:0]  count;

  assign st_ready = !full && !draining;
  assign push     = st_valid && st_ready;

  sdb_store_queue #(.DEPTH(DEPTH), .BLK_AW(BLK_AW), .DATA_W(DATA_W)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_blk  (st_blk),
    .push_data (st_data),
    .pop       (pop),
    .probe_blk (ld_addr[ADDR_W-1:OFFS_W]),
    .probe_hit (hit),
    .head_blk  (head_blk),
    .head_data (head_data),
    .count     (count),
    .full      (full)
  );

  sdb_drain_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_hit    (hit),
    .q_count   (count),
    .mem_ack   (mem_ack),
    .req_valid (mem_req_valid),
    .req_write (mem_req_write),
    .pop       (pop),
    .rsp_fire  (ld_rsp_valid),
    .draining  (draining)
  );

  assign mem_req_addr = mem_req_write ? {head_blk, {OFFS_W{1'b0}}} : ld_addr;
  assign mem_req_data = head_data;
  assign ld_rsp_data  = mem_rdata;
  assign fill_level   = count;
  assign drain_active = draining;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_ack) |=> (mem_req_valid && $stable(mem_req_write)
      && $stable(mem_req_addr) && (!mem_req_write || $stable(mem_req_data)))); // R4
  AST_NO_STORE_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (draining && st_valid) |=> (fill_level <= $past(fill_level))); // R8
  AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rsp_valid |-> (mem_req_valid && !mem_req_write && ld_valid)); // R9

endmodule

// File: tb/store_drain_buffer_tb.sv
module store_drain_buffer_tb;
  localparam int ADDR_W = 16;
  localparam int OFFS_W = 3;
  localparam int DATA_W = 64;
  localparam int DEPTH  = 4;
  localparam int BLK_AW = ADDR_W - OFFS_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              st_valid;
  logic              st_ready;
  logic [BLK_AW-1:0] st_blk;
  logic [DATA_W-1:0] st_data;
  logic              ld_valid;
  logic [ADDR_W-1:0] ld_addr;
  logic              ld_rsp_valid;
  logic [DATA_W-1:0] ld_rsp_data;
  logic              mem_req_valid, mem_req_write;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [DATA_W-1:0] mem_req_data;
  logic              mem_ack;
  logic [DATA_W-1:0] mem_rdata;
  logic [CNT_W-1:0]  fill_level;
  logic              drain_active;

  always #5 clk = ~clk;

  store_drain_buffer #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_blk(st_blk), .st_data(st_data),
    .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .fill_level(fill_level), .drain_active(drain_active)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] rd_pattern(input logic [ADDR_W-1:0] a);
    return {a, ~a, a ^ 16'h5A5A, 16'hC3C3};
  endfunction

  // memory model and transaction log
  int          cur_lat = 0;
  bit          mem_hold = 1'b0;
  bit          in_scn = 1'b0;
  bit          rsp_flag = 1'b0;
  int          wait_cnt = 0;
  int          log_n = 0;
  bit          log_wr   [8];
  logic [15:0] log_addr [8];
  logic [63:0] log_data [8];
  bit          was_wait = 1'b0;
  logic [15:0] w_addr;
  logic [63:0] w_data;
  bit          w_wr;
  bit          cnt_chk = 1'b0;
  logic [CNT_W-1:0] cnt_exp;
  int          flush_seen = 0;

  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
  end

  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (cnt_chk) begin
      #1;
      chk(fill_level == cnt_exp, "R3 release", 64'(fill_level), 64'(cnt_exp));
      cnt_chk = 1'b0;
    end
    if (was_wait)
      chk(mem_req_valid && mem_req_write == w_wr && mem_req_addr == w_addr &&
          (!w_wr || mem_req_data == w_data), "R4 held",
          64'(mem_req_addr), 64'(w_addr));
    was_wait = 1'b0;
    if (rst_n && mem_req_valid) begin
      if (!mem_hold && wait_cnt >= cur_lat) begin
        wait_cnt = 0;
        mem_ack = 1'b1;
        mem_rdata = rd_pattern(mem_req_addr);
        if (log_n < 8) begin
          log_wr[log_n]   = mem_req_write;
          log_addr[log_n] = mem_req_addr;
          log_data[log_n] = mem_req_data;
        end
        log_n++;
        #1;
        if (mem_req_write) begin
          chk(!ld_rsp_valid, "R9 no rsp on write", 64'(ld_rsp_valid), 64'd0);
          cnt_chk = 1'b1;
          cnt_exp = fill_level - 1'b1;
        end else begin
          chk(ld_rsp_valid && ld_rsp_data == rd_pattern(mem_req_addr), "R9 rsp data",
              ld_rsp_data, rd_pattern(mem_req_addr));
          rsp_flag = 1'b1;
        end
      end else begin
        if (!mem_hold) wait_cnt++;
        was_wait = 1'b1;
        w_addr = mem_req_addr;
        w_data = mem_req_data;
        w_wr   = mem_req_write;
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (in_scn && drain_active) begin
      flush_seen++;
      chk(!st_ready, "R8 stall in drain", 64'(st_ready), 64'd0);
      chk(!mem_req_valid || mem_req_write, "R7 no read in drain",
          64'(mem_req_write), 64'd1);
    end
  end

  task automatic push_store(input logic [BLK_AW-1:0] b, input logic [63:0] d,
                            input int exp_cnt);
    @(negedge clk);
    st_valid = 1'b1;
    st_blk   = b;
    st_data  = d;
    #1;
    chk(st_ready, "R2 accept", 64'(st_ready), 64'd1);
    @(negedge clk);
    st_valid = 1'b0;
    #1;
    chk(int'(fill_level) == exp_cnt, "R2 count up", 64'(fill_level), 64'(exp_cnt));
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int scn = 0;
    rst_n    = 1'b0;
    st_valid = 1'b0;
    st_blk   = '0;
    st_data  = '0;
    ld_valid = 1'b0;
    ld_addr  = '0;
    repeat (3) @(negedge clk);
    chk(fill_level == 0, "R1 count", 64'(fill_level), 64'd0);
    chk(!drain_active, "R1 drain", 64'(drain_active), 64'd0);
    chk(!mem_req_valid, "R1 req", 64'(mem_req_valid), 64'd0);
    chk(st_ready, "R1 ready", 64'(st_ready), 64'd1);
    chk(!ld_rsp_valid, "R1 rsp", 64'(ld_rsp_valid), 64'd0);
    rst_n = 1'b1;

    for (int lat = 0; lat < 3; lat++) begin
      for (int n = 0; n <= DEPTH; n++) begin
        for (int m = -1; m < n; m++) begin
          logic [BLK_AW-1:0] base;
          logic [ADDR_W-1:0] la;
          int t;
          int k;
          base = BLK_AW'(scn * 8);
          cur_lat  = lat;
          mem_hold = 1'b1;
          wait_cnt = 0;
          log_n    = 0;
          rsp_flag = 1'b0;
          flush_seen = 0;
          in_scn   = 1'b1;
          for (int i = 0; i < n; i++)
            push_store(base + BLK_AW'(i), {16'(base) + 16'(i), 16'hD00D, 32'(scn)}, i + 1);
          if (n == DEPTH) begin
            // R2: full queue refuses a store
            @(negedge clk);
            st_valid = 1'b1;
            st_blk   = base + 7;
            st_data  = 64'hBAD;
            #1;
            chk(!st_ready, "R2 full stall", 64'(st_ready), 64'd0);
            @(negedge clk);
            st_valid = 1'b0;
            #1;
            chk(int'(fill_level) == DEPTH, "R2 full count", 64'(fill_level), 64'(DEPTH));
          end
          // R6: offset bits nonzero; mismatching load uses a foreign block
          if (m >= 0) la = {base + BLK_AW'(m), OFFS_W'(m + 1)};
          else        la = {base + BLK_AW'(6), OFFS_W'(5)};
          @(negedge clk);
          ld_valid = 1'b1;
          ld_addr  = la;
          mem_hold = 1'b0;
          t = 0;
          while (!rsp_flag && t < 500) begin
            @(negedge clk);
            t++;
          end
          chk(rsp_flag, "R9 response seen", 64'(rsp_flag), 64'd1);
          ld_valid = 1'b0;
          t = 0;
          while ((fill_level != 0 || mem_req_valid) && t < 500) begin
            @(negedge clk);
            t++;
          end
          @(negedge clk);
          in_scn = 1'b0;
          // expected order of memory transactions
          chk(log_n == n + 1, "R3 transaction count", 64'(log_n), 64'(n + 1));
          k = 0;
          for (int j = 0; j <= n && j < 8; j++) begin
            bit is_rd;
            if (m >= 0) is_rd = (j == n);
            else        is_rd = (n == 0) ? (j == 0) : (j == 1);
            if (is_rd) begin
              chk(!log_wr[j] && log_addr[j] == la,
                  (m >= 0) ? "R7 read after full drain" : "R5 read bypasses queue",
                  64'(log_addr[j]), 64'(la));
            end else begin
              chk(log_wr[j] && log_addr[j] == {base + BLK_AW'(k), OFFS_W'(0)} &&
                  log_data[j] == {16'(base) + 16'(k), 16'hD00D, 32'(scn)},
                  "R3 write order", 64'(log_addr[j]),
                  64'({base + BLK_AW'(k), OFFS_W'(0)}));
              k++;
            end
          end
          // R6 / R7: drain happens exactly when the block matches
          chk((flush_seen > 0) == (m >= 0), "R6 match decides drain",
              64'(flush_seen), 64'(m >= 0));
          scn++;
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule